// File: doc/BRIEF.md
# Multi-Mode GPIO Port Controller

This block controls one port of eight general-purpose pins. Software sets each pin to one of four drive styles: high-impedance input, push-pull output, open-drain output, or quasi-bidirectional. The block turns the per-pin style and output data bit into three pad controls: output enable, output value and weak pull-up enable. It also brings the pad levels back through a two-flop synchronizer, so software can read them.

Software talks to the block through a plain single-cycle register port. There is a write strobe with a word address and write data, and a combinational read-data bus that decodes the same address. Three word offsets are mapped. Offset 0x0 is the per-pin style register. Offset 0x4 is the output latch. Offset 0x8 is the read-only pad level register.

In quasi-bidirectional mode, a latch bit that goes from 0 to 1 gets a short strong-high pulse. This pulse pulls the line up quickly before the weak pull-up takes over. The port leaves reset in quasi-bidirectional mode with every latch bit set.

Top module: `gpio_port_ctrl`

## Requirements
- R1: The style register sits at offset 0x0. Pin n uses bits [2n+1:2n]. The output latch sits at offset 0x4, bits [7:0]. The pad level register sits at offset 0x8, bits [7:0]. Unused bits, and any unmapped offset such as 0xC, read as zero.
- R2: After reset, offset 0x0 reads 0xFFFF (every pin code 11) and offset 0x4 reads 0xFF. Every pad has output enable 0 and pull-up enable 1.
- R3: In code 00 (input), output enable is 0 and pull-up enable is 0, whatever the latch bit holds.
- R4: In code 01 (push-pull), output enable is 1, the output value equals the latch bit, and pull-up enable is 0.
- R5: In code 10 (open-drain), a latch bit of 0 gives output enable 1, output value 0 and pull-up 0. A latch bit of 1 gives output enable 0 and pull-up 1. The output value is never 1 while the output is enabled.
- R6: In code 11 (quasi-bidirectional) with a steady latch, a bit of 0 gives output enable 1, output value 0 and pull-up 0. A bit of 1 gives output enable 0 and pull-up 1.
- R7: In code 11, a latch bit that goes from 0 to 1 drives output enable 1, output value 1 and pull-up 1 for exactly two clock cycles. After that the pin falls back to the weak pull-up alone. Rewriting a bit that is already 1 gives no pulse.
- R8: The pad level register shows the pad input two clock edges after the change, in every code.
- R9: A write takes effect on the clock edge at which its strobe is sampled. Writes to offset 0x8 or to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 4 | Word byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven value |
| pad_pu_en | output | 8 | Per-pin weak pull-up enable |

## Verification
The assertions assume that the register strobe, address and write data are stable around the sampling edge. They also assume the pad inputs are quiet enough that their level two edges back is meaningful. The bench changes every input only on the falling clock edge, so all of these hold. The pulse checks assume the style stays at code 11 and the latch bit stays at 1 during the pulse. The directed scenarios never write the port in the two cycles after a rising latch bit.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    PIN_INPUT = 2'b00,
    PIN_PUSH  = 2'b01,
    PIN_DRAIN = 2'b10,
    PIN_QUASI = 2'b11
  } pin_style_e;

  typedef struct packed {
    logic oe;
    logic val;
    logic pu;
  } pad_ctl_t;

  // Pad controls for one pin from its style, latch bit and boost state.
  function automatic pad_ctl_t style_to_pad(pin_style_e style, logic bit_d, logic boost);
    pad_ctl_t c;
    c = '{oe: 1'b0, val: 1'b0, pu: 1'b0};
    unique case (style)
      PIN_INPUT: c = '{oe: 1'b0, val: 1'b0, pu: 1'b0};
      PIN_PUSH:  c = '{oe: 1'b1, val: bit_d, pu: 1'b0};
      PIN_DRAIN: c = bit_d ? '{oe: 1'b0, val: 1'b0, pu: 1'b1}
                           : '{oe: 1'b1, val: 1'b0, pu: 1'b0};
      PIN_QUASI: begin
        if (!bit_d)     c = '{oe: 1'b1, val: 1'b0, pu: 1'b0};
        else if (boost) c = '{oe: 1'b1, val: 1'b1, pu: 1'b1};
        else            c = '{oe: 1'b0, val: 1'b0, pu: 1'b1};
      end
      default: c = '{oe: 1'b0, val: 1'b0, pu: 1'b0};
    endcase
    return c;
  endfunction

  // Width of a down-counter that holds values 0..n.
  function automatic int cnt_width(int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter logic [ADDR_W-1:0] OFS_STYLE = 'h0,
  parameter logic [ADDR_W-1:0] OFS_LATCH = 'h4,
  parameter logic [ADDR_W-1:0] OFS_LEVEL = 'h8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [NUM_PINS-1:0]   level,
  output logic [2*NUM_PINS-1:0] style_q,
  output logic [NUM_PINS-1:0]   latch_q,
  output logic [DATA_W-1:0]     rdata
);
  localparam int STYLE_W = 2 * NUM_PINS;

  logic hit_style, hit_latch;
  assign hit_style = wr && (addr == OFS_STYLE);
  assign hit_latch = wr && (addr == OFS_LATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      style_q <= '1;
      latch_q <= '1;
    end else begin
      if (hit_style) style_q <= wdata[STYLE_W-1:0];
      if (hit_latch) latch_q <= wdata[NUM_PINS-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == OFS_STYLE)      rdata[STYLE_W-1:0]  = style_q;
    else if (addr == OFS_LATCH) rdata[NUM_PINS-1:0] = latch_q;
    else if (addr == OFS_LEVEL) rdata[NUM_PINS-1:0] = level;
  end

  logic unused_wdata_hi;
  assign unused_wdata_hi = &{1'b0, wdata[DATA_W-1:STYLE_W]};

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
  import gpio_pkg::*;
#(
  parameter int BOOST_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] style,
  input  logic       bit_d,
  output logic       boost,
  output logic       oe,
  output logic       val,
  output logic       pu
);
  localparam int CNT_W = cnt_width(BOOST_CYCLES);

  logic             bit_prev;
  logic [CNT_W-1:0] cnt;
  logic             is_quasi, rise;
  pad_ctl_t         ctl;

  assign is_quasi = (pin_style_e'(style) == PIN_QUASI);
  assign rise     = is_quasi && bit_d && !bit_prev;
  assign boost    = rise || (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_prev <= 1'b1;
      cnt      <= '0;
    end else begin
      bit_prev <= bit_d;
      if (!is_quasi || !bit_d) cnt <= '0;
      else if (rise)           cnt <= CNT_W'(BOOST_CYCLES - 1);
      else if (cnt != '0)      cnt <= cnt - 1'b1;
    end
  end

  assign ctl = style_to_pad(pin_style_e'(style), bit_d, boost);
  assign oe  = ctl.oe;
  assign val = ctl.val;
  assign pu  = ctl.pu;

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int NUM_PINS     = 8,
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 32,
  parameter int BOOST_CYCLES = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_pu_en
);
  logic [2*NUM_PINS-1:0] style_q;
  logic [NUM_PINS-1:0]   latch_q;
  logic [NUM_PINS-1:0]   level_q;
  logic [NUM_PINS-1:0]   boost_vec;

  gpio_regs #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .level(level_q), .style_q(style_q), .latch_q(latch_q), .rdata(reg_rdata)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(level_q)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_drive #(.BOOST_CYCLES(BOOST_CYCLES)) u_drv (
      .clk(clk), .rst_n(rst_n),
      .style(style_q[2*p+1:2*p]), .bit_d(latch_q[p]),
      .boost(boost_vec[p]),
      .oe(pad_oe[p]), .val(pad_out[p]), .pu(pad_pu_en[p])
    );
  end

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic [NUM_PINS-1:0]   wdata_lo,
  input logic [NUM_PINS-1:0]   pad_in,
  input logic [NUM_PINS-1:0]   pad_oe,
  input logic [NUM_PINS-1:0]   pad_out,
  input logic [NUM_PINS-1:0]   pad_pu_en,
  input logic [2*NUM_PINS-1:0] style_q,
  input logic [NUM_PINS-1:0]   latch_q,
  input logic [NUM_PINS-1:0]   level_q,
  input logic [NUM_PINS-1:0]   boost_vec
);
  logic [1:0] edges_live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edges_live <= '0;
    else if (edges_live != 2'd3) edges_live <= edges_live + 2'd1;
  end

  // R9: a latch write lands on the edge that samples it
  a_r9_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(4)) |=> (latch_q == $past(wdata_lo)));

  // R8: pad levels reach the register two edges later
  a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_live >= 2'd2) |-> (level_q == $past(pad_in, 2)));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    a_r3_input_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      (style_q[2*p+1:2*p] == 2'b00) |-> (!pad_oe[p] && !pad_pu_en[p]));

    a_r4_push_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (style_q[2*p+1:2*p] == 2'b01) |-> (pad_oe[p] && pad_out[p] == latch_q[p] && !pad_pu_en[p]));

    a_r5_drain_no_high: assert property (@(posedge clk) disable iff (!rst_n)
      (style_q[2*p+1:2*p] == 2'b10) |-> !(pad_oe[p] && pad_out[p]));

    a_r7_boost_second: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(boost_vec[p]) |=> (boost_vec[p] || style_q[2*p+1:2*p] != 2'b11 || !latch_q[p]));

    a_r7_boost_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (boost_vec[p] && $past(boost_vec[p])) |=> !boost_vec[p]);

    a_r6_quasi_high_weak: assert property (@(posedge clk) disable iff (!rst_n)
      (style_q[2*p+1:2*p] == 2'b11 && latch_q[p] && !boost_vec[p]) |-> (!pad_oe[p] && pad_pu_en[p]));
  end

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wdata_lo(reg_wdata[NUM_PINS-1:0]), .pad_in(pad_in), .pad_oe(pad_oe),
  .pad_out(pad_out), .pad_pu_en(pad_pu_en), .style_q(style_q),
  .latch_q(latch_q), .level_q(level_q), .boost_vec(boost_vec)
);

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_oe, pad_out, pad_pu_en;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu_en(pad_pu_en)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic pads(string req, logic [7:0] oe, logic [7:0] o, logic [7:0] pu);
    chk({req, " oe"}, {24'd0, pad_oe}, {24'd0, oe});
    chk({req, " out"}, {24'd0, pad_out & pad_oe}, {24'd0, o});
    chk({req, " pu"}, {24'd0, pad_pu_en}, {24'd0, pu});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    rd(4'h0, v); chk("R2 style reset", v, 32'hFFFF);
    rd(4'h4, v); chk("R2 latch reset", v, 32'hFF);
    pads("R2", 8'h00, 8'h00, 8'hFF);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(4'h0, 32'hABCD_1B6C);
    rd(4'h0, v); chk("R1 style field", v, 32'h1B6C);
    wr(4'h4, 32'h1234_5A3C);
    rd(4'h4, v); chk("R1 latch field", v, 32'h3C);
    rd(4'hC, v); chk("R1 unmapped", v, 32'h0);
  endtask

  task automatic t_input();
    wr(4'h0, 32'h0000);
    wr(4'h4, 32'h55);
    pads("R3", 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_push();
    wr(4'h0, 32'h5555);
    pads("R4", 8'hFF, 8'h55, 8'h00);
    wr(4'h4, 32'hC3);
    pads("R4 update", 8'hFF, 8'hC3, 8'h00);
  endtask

  task automatic t_drain();
    wr(4'h0, 32'hAAAA);
    wr(4'h4, 32'h0F);
    pads("R5", 8'hF0, 8'h00, 8'h0F);
  endtask

  task automatic t_quasi_boost();
    wr(4'h0, 32'hFFFF);
    wr(4'h4, 32'h00);
    pads("R6 low", 8'hFF, 8'h00, 8'h00);
    wr(4'h4, 32'h0F);
    pads("R7 boost c1", 8'hFF, 8'h0F, 8'h0F);
    @(negedge clk);
    pads("R7 boost c2", 8'hFF, 8'h0F, 8'h0F);
    @(negedge clk);
    pads("R7 boost end", 8'hF0, 8'h00, 8'h0F);
    wr(4'h4, 32'h0F);
    pads("R7 no repulse", 8'hF0, 8'h00, 8'h0F);
    // push-pull high then quasi: bit already 1, no pulse
    wr(4'h0, 32'h5555);
    wr(4'h4, 32'hFF);
    wr(4'h0, 32'hFFFF);
    pads("R6 steady high", 8'h00, 8'h00, 8'hFF);
  endtask

  task automatic t_sync();
    logic [31:0] v;
    wr(4'h0, 32'h5555);
    @(negedge clk); pad_in = 8'hA5;
    @(negedge clk); rd(4'h8, v); chk("R8 one edge", v, 32'h00);
    @(negedge clk); rd(4'h8, v); chk("R8 two edges", v, 32'hA5);
    wr(4'h0, 32'h0000);
    pad_in = 8'h3C;
    @(negedge clk); @(negedge clk); rd(4'h8, v); chk("R8 input mode", v, 32'h3C);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    wr(4'h0, 32'h1234);
    wr(4'h4, 32'h66);
    wr(4'h8, 32'h0000);
    wr(4'hC, 32'hFFFF);
    rd(4'h0, v); chk("R9 style kept", v, 32'h1234);
    rd(4'h4, v); chk("R9 latch kept", v, 32'h66);
    rd(4'h8, v); chk("R9 level kept", v, 32'h3C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_input();
    t_push();
    t_drain();
    t_quasi_boost();
    t_sync();
    t_ignored();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule